// File: doc/BRIEF.md
# Boundary-Scan Test Port with Reconfiguration Request

This block is the serial test port of a configuration-memory device. A 16-state test controller advances on the rising edge of the test clock, steered by the mode-select input. It owns a 10-bit instruction register and four data paths:

- a single bypass bit;
- a fixed 32-bit identity word;
- a 32-bit user word taken from an input port;
- a boundary chain whose length is a parameter. The chain sits between the core's functional outputs and the pads.

One extra instruction asks the attached programmable logic to reload itself. It drives an active-low request pin, and that pin is low only while the controller rests in Run-Test/Idle.

While the configuration engine reports that it is busy, the port must not disturb the device. New instructions are refused, and the pads keep carrying their functional values. Test access is meant for the periods before and after configuration.

Top module: `tap_reconfig`

## Requirements
- R1: An asserted `trst_n`, or five consecutive rising clocks with `tms` high, puts the controller in Test-Logic-Reset. That state loads the identity opcode 10'h059 as the current instruction.
- R2: Capture-IR loads the pattern 10'b00_0000_0001 into the instruction shift stage. It is shifted out least significant bit first.
- R3: Opcode 10'h059 selects the identity path. It shifts out 32'h010020DD least significant bit first.
- R4: Opcode 10'h079 selects the user path. It shifts out the value on `ucode` as captured in Capture-DR, least significant bit first.
- R5: Opcode 10'h3FF, and every opcode not named in these requirements, selects the bypass bit. That bit captures 0 and delays `tdi` by one clock.
- R6: Opcode 10'h055 (sample/preload) captures `pad_in` into the chain, and cell 0 is shifted out first. Update-DR copies the chain into the update stage. `pad_out` keeps following `func_out`.
- R7: Opcode 10'h000 (external test) drives `pad_out` from the update stage, and the chain captures `pad_in`. This lets values preloaded under R6 reach the pads as soon as the instruction takes effect.
- R8: Once opcode 10'h061 is the current instruction, `reconf_n` is low in every cycle the controller is in Run-Test/Idle. It goes high in the state that follows Run-Test/Idle.
- R9: While `busy` is high, Update-IR leaves the current instruction unchanged, and `pad_out` equals `func_out`.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only after a falling edge in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| busy | input | 1 | Configuration engine is running |
| ucode | input | 32 | User-programmed code word |
| pad_in | input | BS_LEN | Values seen at the device pads |
| func_out | input | BS_LEN | Functional values from the core |
| pad_out | output | BS_LEN | Values driven to the pads |
| reconf_n | output | 1 | Reconfiguration request, active low |

## Verification
The bench reads the captured instruction pattern and checks that a design which captured the wrong constant, or shifted most significant bit first, shows up in the first Shift-IR bits. It preloads a chain pattern under sample mode and then switches to external test. A design that ties the update stage to the test instruction, or updates it from the wrong path, puts the wrong value on the pads. It raises `busy` and then tries an instruction load. A design that ignores `busy` would change the selected path and drive the pads. It watches `reconf_n` across entry to and exit from Run-Test/Idle, and it samples `tdo` between a rising and a falling edge. A design that updates `tdo` on the rising edge fails that mid-cycle check.

// File: rtl/tap_reconfig.sv
module tap_reconfig #(
  parameter int          BS_LEN   = 8,
  parameter logic [31:0] ID_VALUE = 32'h010020DD
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic              busy,
  input  logic [31:0]       ucode,
  input  logic [BS_LEN-1:0] pad_in,
  input  logic [BS_LEN-1:0] func_out,
  output logic [BS_LEN-1:0] pad_out,
  output logic              reconf_n
);
  localparam int IRW = 10;
  localparam logic [IRW-1:0] OP_EXT  = 10'h000;
  localparam logic [IRW-1:0] OP_SMP  = 10'h055;
  localparam logic [IRW-1:0] OP_ID   = 10'h059;
  localparam logic [IRW-1:0] OP_USR  = 10'h079;
  localparam logic [IRW-1:0] OP_RCF  = 10'h061;
  localparam logic [IRW-1:0] IR_CAPT = 10'h001;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_st_t;

  tap_st_t st, st_nx;
  logic [IRW-1:0]    ir, ir_sr;
  logic              byp;
  logic [31:0]       w_sr;
  logic [BS_LEN-1:0] bs_sr, bs_upd;

  wire sel_bsr = (ir == OP_EXT) || (ir == OP_SMP);
  wire sel_wrd = (ir == OP_ID) || (ir == OP_USR);

  always_comb begin
    case (st)
      TLR:     st_nx = tms ? TLR    : RTI;
      RTI:     st_nx = tms ? SEL_DR : RTI;
      SEL_DR:  st_nx = tms ? SEL_IR : CAP_DR;
      CAP_DR:  st_nx = tms ? EX1_DR : SH_DR;
      SH_DR:   st_nx = tms ? EX1_DR : SH_DR;
      EX1_DR:  st_nx = tms ? UPD_DR : PA_DR;
      PA_DR:   st_nx = tms ? EX2_DR : PA_DR;
      EX2_DR:  st_nx = tms ? UPD_DR : SH_DR;
      UPD_DR:  st_nx = tms ? SEL_DR : RTI;
      SEL_IR:  st_nx = tms ? TLR    : CAP_IR;
      CAP_IR:  st_nx = tms ? EX1_IR : SH_IR;
      SH_IR:   st_nx = tms ? EX1_IR : SH_IR;
      EX1_IR:  st_nx = tms ? UPD_IR : PA_IR;
      PA_IR:   st_nx = tms ? EX2_IR : PA_IR;
      EX2_IR:  st_nx = tms ? UPD_IR : SH_IR;
      default: st_nx = tms ? SEL_DR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      st     <= TLR;
      ir     <= OP_ID;
      ir_sr  <= '0;
      byp    <= 1'b0;
      w_sr   <= '0;
      bs_sr  <= '0;
      bs_upd <= '0;
    end else begin
      st <= st_nx;
      if (st == TLR)
        ir <= OP_ID;
      else if (st == UPD_IR && !busy)
        ir <= ir_sr;
      if (st == CAP_IR)
        ir_sr <= IR_CAPT;
      else if (st == SH_IR)
        ir_sr <= {tdi, ir_sr[IRW-1:1]};
      if (st == CAP_DR) begin
        byp   <= 1'b0;
        w_sr  <= (ir == OP_USR) ? ucode : ID_VALUE;
        bs_sr <= pad_in;
      end else if (st == SH_DR) begin
        byp   <= tdi;
        w_sr  <= {tdi, w_sr[31:1]};
        if (BS_LEN > 1)
          bs_sr <= {tdi, bs_sr[BS_LEN-1:1]};
        else
          bs_sr <= tdi;
      end
      if (st == UPD_DR && sel_bsr)
        bs_upd <= bs_sr;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == SH_DR) || (st == SH_IR);
      if (st == SH_IR)      tdo <= ir_sr[0];
      else if (sel_bsr)     tdo <= bs_sr[0];
      else if (sel_wrd)     tdo <= w_sr[0];
      else                  tdo <= byp;
    end
  end

  assign pad_out  = (ir == OP_EXT && !busy) ? bs_upd : func_out;
  assign reconf_n = !(ir == OP_RCF && st == RTI);

  a_r1_reset_loads_id: assert property (@(posedge tck) disable iff (!trst_n)
    (st == TLR) |=> (ir == OP_ID));
  a_r2_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    (st == CAP_IR) |=> (ir_sr == IR_CAPT));
  a_r8_reconf_on_idle: assert property (@(posedge tck) disable iff (!trst_n)
    (st == UPD_IR && !busy && ir_sr == OP_RCF && !tms) |=> !reconf_n);
  a_r9_busy_blocks_ir: assert property (@(posedge tck) disable iff (!trst_n)
    (st == UPD_IR && busy) |=> $stable(ir));
  a_r9_busy_functional: assert property (@(posedge tck) disable iff (!trst_n)
    busy |-> (pad_out == func_out));
endmodule

// File: tb/sim_tap_reconfig.sv
module sim_tap_reconfig;
  localparam int N = 8;
  logic tck = 0, trst_n = 0, tms = 1, tdi = 0, busy = 0;
  logic [31:0] ucode = 32'hCAFE1234;
  logic [N-1:0] pad_in = '0, func_out = 8'h3C;
  logic tdo, tdo_oe, reconf_n;
  logic [N-1:0] pad_out;
  int total = 0, bad = 0;
  logic [63:0] got;
  logic [9:0] irc;

  tap_reconfig #(.BS_LEN(N)) u0 (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .busy(busy), .ucode(ucode), .pad_in(pad_in),
    .func_out(func_out), .pad_out(pad_out), .reconf_n(reconf_n));

  always #10 tck = ~tck;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [9:0] op, output logic [9:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 10; i++) begin
      cap[i] = tdo;
      tick(i == 9, op[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic t_reset;
    trst_n = 0; #45;
    check("R1 oe in reset", tdo_oe, 0);
    check("R8 reconf idle in reset", reconf_n, 1);
    check("R7 pads functional in reset", pad_out, func_out);
    @(negedge tck); #1; trst_n = 1;
    tick(0, 0);
    scan_dr(0, 32, got);
    check("R3 idcode after trst", got[31:0], 32'h010020DD);
  endtask

  task automatic t_ir_capture_user;
    load_ir(10'h079, irc);
    check("R2 capture-ir pattern", irc, 10'h001);
    scan_dr(0, 32, got);
    check("R4 usercode", got[31:0], 32'hCAFE1234);
    ucode = 32'h0F0F_5AA5;
    scan_dr(0, 32, got);
    check("R4 usercode new value", got[31:0], 32'h0F0F_5AA5);
  endtask

  task automatic t_bypass;
    load_ir(10'h3FF, irc);
    scan_dr(64'hB, 4, got);
    check("R5 bypass delay", got[3:0], 4'b0110);
    load_ir(10'h2A5, irc);
    scan_dr(64'h5, 4, got);
    check("R5 unlisted opcode as bypass", got[3:0], 4'b1010);
    check("R10 oe low in idle", tdo_oe, 0);
    tick(1, 0); tick(0, 0); tick(0, 0);
    check("R10 oe high in shift", tdo_oe, 1);
    check("R10 first bypass bit", tdo, 0);
    tms = 0; tdi = 1;
    @(posedge tck); #2;
    check("R10 tdo held after rising edge", tdo, 0);
    @(negedge tck); #1;
    check("R10 tdo updated at falling edge", tdo, 1);
    tick(1, 0); tick(1, 0); tick(0, 0);
  endtask

  task automatic t_tms_reset_busy;
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    busy = 1;
    load_ir(10'h000, irc);
    check("R9 pads functional while busy", pad_out, func_out);
    scan_dr(0, 32, got);
    check("R1 R9 idcode kept after tms reset and busy", got[31:0], 32'h010020DD);
    busy = 0;
  endtask

  task automatic t_boundary;
    pad_in = 8'hA5;
    load_ir(10'h055, irc);
    scan_dr(64'h96, N, got);
    check("R6 sample captures pads", got[N-1:0], 8'hA5);
    check("R6 pads functional in sample", pad_out, func_out);
    load_ir(10'h000, irc);
    check("R7 preload reaches pads", pad_out, 8'h96);
    pad_in = 8'h5A;
    scan_dr(64'h0F, N, got);
    check("R7 extest captures pads", got[N-1:0], 8'h5A);
    check("R7 extest drives update value", pad_out, 8'h0F);
  endtask

  task automatic t_reconf;
    load_ir(10'h061, irc);
    check("R8 low in idle", reconf_n, 0);
    tick(0, 0);
    check("R8 low while staying idle", reconf_n, 0);
    tick(1, 0);
    check("R8 released on leaving idle", reconf_n, 1);
    tick(1, 0); tick(1, 0); tick(0, 0);
    check("R1 R8 reset clears request", reconf_n, 1);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ir_capture_user();
    t_bypass();
    t_tms_reset_busy();
    t_boundary();
    t_reconf();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule